// File: doc/BRIEF.md
# Second-Level Page Descriptor Walker

This block performs the second stage of a two-level page-table translation. It is given a virtual address, the first-level descriptor that points at a second-level table, a flag saying whether that table is coarse or fine, and the domain number of the region. It reads one second-level descriptor through a single-outstanding read port. The port has a request handshake and a response that may arrive after any number of cycles. The block then decodes the descriptor.

The two low descriptor bits select the result. Type 0 is a translation fault. Type 1 is a 64 KB page and type 2 is a 4 KB page. For both, the physical address is formed at the page's own boundary, and the two permission bits are taken from one of four subpage fields. Type 3 is a 1 KB page. It is refused when found in a coarse table.

The result is presented with a one-cycle completion pulse and stays on the outputs until the next walk is started. Permission checking against domain control and any TLB fill are done by neighbouring logic.

Top module: `l2_page_walker`

## Requirements
- R1: On an accepted start, the block raises `rd_req_valid` with `rd_addr` = {`l1_desc`[31:10], `vaddr`[19:12], 2'b00}. Both stay unchanged until a cycle with `rd_req_ready` high, and the request is dropped in the cycle after that handshake.
- R2: A descriptor whose bits [1:0] are 2'b00 gives `fault`=1 with status code 4'h7.
- R3: A descriptor of type 2'b01 (64 KB page) gives `paddr` = {desc[31:16], `vaddr`[15:0]}.
- R4: A descriptor of type 2'b10 (4 KB page) gives `paddr` = {desc[31:12], `vaddr`[11:0]}.
- R5: For types 2'b01 and 2'b10, `perm` is the two descriptor bits starting at bit 4 + 2·`vaddr`[15:14].
- R6: A descriptor of type 2'b11 (1 KB page) with `coarse`=1 gives a fault with code 4'h7. With `coarse`=0 it gives `paddr` = {desc[31:10], `vaddr`[9:0]} and `perm` = desc[5:4].
- R7: `fault_status` is {`domain`, code}, where the code is 4'hF on success. On a fault, `paddr` and `perm` are zero.
- R8: `done` is high for exactly one cycle per walk, in the cycle after the response is accepted. That is the cycle where `rd_resp_valid` is high after the request handshake.
- R9: `start` is ignored while a walk is in progress. The request address and the result stay those of the walk already running.
- R10: `done`, `fault`, `fault_status`, `paddr` and `perm` are zero after reset. The last four hold their values from the `done` pulse until the next accepted walk delivers a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| l1_desc | input | 32 | First-level descriptor holding the table base |
| coarse | input | 1 | 1 = coarse second-level table, 0 = fine |
| domain | input | 4 | Domain number for the fault status |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 32 | Descriptor fetch address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Fetched descriptor |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| fault_status | output | 8 | {domain, code} |
| paddr | output | 32 | Physical address |
| perm | output | 2 | Access-permission bits |

## Verification
The hardest situation to create is a `start` that arrives while a walk is still waiting. The bench produces it by stretching the memory's ready and response delays to several cycles. It then pulses `start` with a different address and domain in the middle of the wait. It checks that the request address stays unchanged, that only one `done` follows, and that the result belongs to the first walk. The bench also sweeps all four subpage indices and both table kinds for the 1 KB type, so that each permission field and the coarse-table refusal are reached.

// File: rtl/l2_page_walker.sv
module l2_page_walker #(
  parameter int DOM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      vaddr,
  input  logic [31:0]      l1_desc,
  input  logic             coarse,
  input  logic [DOM_W-1:0] domain,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [31:0]      rd_addr,
  input  logic             rd_resp_valid,
  input  logic [31:0]      rd_resp_data,
  output logic             done,
  output logic             fault,
  output logic [DOM_W+3:0] fault_status,
  output logic [31:0]      paddr,
  output logic [1:0]       perm
);

  localparam logic [3:0] CODE_XLATE = 4'h7;
  localparam logic [3:0] CODE_OK    = 4'hF;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} st_t;

  st_t              state;
  logic             req_sent;
  logic [31:0]      va_q;
  logic [21:0]      base_q;
  logic             coarse_q;
  logic [DOM_W-1:0] dom_q;

  logic             take_start;
  logic             take_resp;
  logic             dec_fault;
  logic [31:0]      dec_paddr;
  logic [1:0]       dec_perm;
  logic [1:0]       sub_perm;

  assign take_start   = (state == S_IDLE) && start;
  assign take_resp    = (state == S_FETCH) && req_sent && rd_resp_valid;
  assign rd_req_valid = (state == S_FETCH) && !req_sent;
  assign rd_addr      = {base_q, va_q[19:12], 2'b00};
  assign done         = (state == S_DONE);

  always_comb begin
    case (va_q[15:14])
      2'd0:    sub_perm = rd_resp_data[5:4];
      2'd1:    sub_perm = rd_resp_data[7:6];
      2'd2:    sub_perm = rd_resp_data[9:8];
      default: sub_perm = rd_resp_data[11:10];
    endcase
  end

  always_comb begin
    dec_fault = 1'b0;
    dec_paddr = '0;
    dec_perm  = '0;
    case (rd_resp_data[1:0])
      2'b00: dec_fault = 1'b1;
      2'b01: begin
        dec_paddr = {rd_resp_data[31:16], va_q[15:0]};
        dec_perm  = sub_perm;
      end
      2'b10: begin
        dec_paddr = {rd_resp_data[31:12], va_q[11:0]};
        dec_perm  = sub_perm;
      end
      default: begin
        if (coarse_q) begin
          dec_fault = 1'b1;
        end else begin
          dec_paddr = {rd_resp_data[31:10], va_q[9:0]};
          dec_perm  = rd_resp_data[5:4];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_sent <= 1'b0;
      va_q     <= '0;
      base_q   <= '0;
      coarse_q <= 1'b0;
      dom_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (take_start) begin
          state    <= S_FETCH;
          req_sent <= 1'b0;
          va_q     <= vaddr;
          base_q   <= l1_desc[31:10];
          coarse_q <= coarse;
          dom_q    <= domain;
        end
        S_FETCH: begin
          if (rd_req_valid && rd_req_ready) req_sent <= 1'b1;
          if (take_resp) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault        <= 1'b0;
      fault_status <= '0;
      paddr        <= '0;
      perm         <= '0;
    end else if (take_resp) begin
      fault        <= dec_fault;
      fault_status <= {dom_q, dec_fault ? CODE_XLATE : CODE_OK};
      paddr        <= dec_paddr;
      perm         <= dec_perm;
    end
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

  p_req_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);

  p_fault_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> fault_status[3:0] == CODE_XLATE && paddr == '0 && perm == '0);

  p_ok_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> fault_status[3:0] == CODE_OK);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> $stable(rd_addr));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_resp |=> $stable(paddr) && $stable(perm) && $stable(fault_status) && $stable(fault));

endmodule

// File: tb/test_l2_page_walker.sv
module test_l2_page_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic [31:0] l1_desc = '0;
  logic        coarse = 1'b0;
  logic [3:0]  domain = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_resp_valid = 1'b0;
  logic [31:0] rd_resp_data = '0;
  logic        done;
  logic        fault;
  logic [7:0]  fault_status;
  logic [31:0] paddr;
  logic [1:0]  perm;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  l2_page_walker i_l2_page_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .l1_desc(l1_desc),
    .coarse(coarse), .domain(domain), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
    .rd_resp_data(rd_resp_data), .done(done), .fault(fault),
    .fault_status(fault_status), .paddr(paddr), .perm(perm)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        e_fault;
  logic [7:0]  e_status;
  logic [31:0] e_paddr;
  logic [1:0]  e_perm;

  task automatic model(input logic [31:0] va, input logic co, input logic [3:0] dom, input logic [31:0] d);
    int t;
    int sh;
    t = int'(d & 32'h3);
    e_fault = 1'b0; e_paddr = 0; e_perm = 0;
    sh = 4 + 2 * int'((va >> 14) & 32'h3);
    if (t == 0 || (t == 3 && co)) e_fault = 1'b1;
    else if (t == 1) begin
      e_paddr = (d & 32'hFFFF0000) | (va & 32'h0000FFFF);
      e_perm = 2'((d >> sh) & 32'h3);
    end else if (t == 2) begin
      e_paddr = (d & 32'hFFFFF000) | (va & 32'h00000FFF);
      e_perm = 2'((d >> sh) & 32'h3);
    end else begin
      e_paddr = (d & 32'hFFFFFC00) | (va & 32'h000003FF);
      e_perm = 2'((d >> 4) & 32'h3);
    end
    e_status = {dom, e_fault ? 4'h7 : 4'hF};
  endtask

  task automatic check_result(input string tag);
    chk(fault == e_fault, {tag, " fault"}, 32'(fault), 32'(e_fault));
    chk(fault_status == e_status, "R7 status", 32'(fault_status), 32'(e_status));
    chk(paddr == e_paddr, {tag, " paddr"}, paddr, e_paddr);
    chk(perm == e_perm, {tag, " perm"}, 32'(perm), 32'(e_perm));
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] l1, input logic co,
                      input logic [3:0] dom, input logic [31:0] d,
                      input int rdy_dly, input int rsp_dly, input bit busy_poke, input string tag);
    logic [31:0] e_addr;
    e_addr = (l1 & 32'hFFFFFC00) | ((va >> 10) & 32'h3FC);
    model(va, co, dom, d);
    @(negedge clk);
    vaddr = va; l1_desc = l1; coarse = co; domain = dom; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_req_valid === 1'b1, "R1 req valid", 32'(rd_req_valid), 1);
    chk(rd_addr == e_addr, "R1 addr", rd_addr, e_addr);
    for (int i = 0; i < rdy_dly; i++) begin
      if (busy_poke && i == 0) begin
        vaddr = ~va; l1_desc = ~l1; domain = ~dom; coarse = ~co; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(rd_req_valid === 1'b1 && rd_addr == e_addr, "R9 addr held while busy", rd_addr, e_addr);
      chk(done === 1'b0, "R8 no early done", 32'(done), 0);
    end
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    chk(rd_req_valid === 1'b0, "R1 req dropped", 32'(rd_req_valid), 0);
    for (int i = 0; i < rsp_dly; i++) begin
      if (busy_poke && i == 0) begin
        vaddr = ~va; domain = ~dom; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b0, "R8 no done before data", 32'(done), 0);
    end
    rd_resp_valid = 1'b1; rd_resp_data = d;
    @(negedge clk);
    rd_resp_valid = 1'b0; rd_resp_data = 32'hDEAD_BEEF;
    chk(done === 1'b1, "R8 done pulse", 32'(done), 1);
    check_result(tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done === 1'b0, "R8 single pulse", 32'(done), 0);
      chk(paddr == e_paddr && fault_status == e_status && perm == e_perm,
          "R10 hold", paddr, e_paddr);
    end
  endtask

  initial begin
    #(20 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 0 && fault === 0 && paddr === 0 && perm === 0 && fault_status === 0 && rd_req_valid === 0,
        "R10 reset state", paddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 type 0 fault
    walk(32'h1234_5678, 32'hABCD_E400, 1'b1, 4'h3, 32'hFFFF_FFF0, 0, 0, 1'b0, "R2");
    // R3 / R5 large page, every subpage
    for (int s = 0; s < 4; s++)
      walk(32'h0007_2ABC | (32'(s) << 14), 32'h0010_0000, 1'b1, 4'h5,
           32'h8765_0000 | 32'h0000_0E4D | (32'(s) << 12), 1, 2, 1'b0, "R3 R5");
    // R4 / R5 small page
    for (int s = 0; s < 4; s++)
      walk(32'hC00F_3123 | (32'(s) << 14), 32'h4000_0C00, 1'b0, 4'hA,
           32'h1357_9000 | 32'h0000_06CE | (32'(s) << 4), 2, 0, 1'b0, "R4 R5");
    // R6 tiny page: fine ok, coarse fault
    walk(32'h89AB_CDEF, 32'h2222_2800, 1'b0, 4'h9, 32'hFEDC_BA63, 0, 1, 1'b0, "R6 fine");
    walk(32'h89AB_CDEF, 32'h2222_2800, 1'b1, 4'h9, 32'hFEDC_BA63, 1, 0, 1'b0, "R6 coarse");
    // R9 start while busy, long latencies
    walk(32'h0055_AA00, 32'h7777_7400, 1'b0, 4'h1, 32'h2468_ACE2, 4, 5, 1'b1, "R9");
    // R10 result holds across idle start-free cycles then changes on next walk
    repeat (5) @(negedge clk);
    chk(paddr == e_paddr && fault == e_fault, "R10 idle hold", paddr, e_paddr);
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'hF, 32'hFFFF_FFFF, 0, 0, 1'b0, "R6 all ones");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule